// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block merges sixteen numbered interrupt request inputs into a single interrupt line toward a processor. Internally it behaves as two eight-line priority stages in cascade. The upper stage (lines 8 to 15) reports into slot 2 of the lower stage (lines 0 to 7). Slot 2 therefore carries no device of its own, and fifteen request lines remain usable.

Because the whole upper stage inherits the rank of slot 2, the service order is 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.

The processor uses the block in four steps:
- It programs a per-line mask word.
- It waits for `irq_o`.
- It pulses `ack_i` to read the winning line number on `vec_o`.
- It pulses `eoi_i` when its handler ends.

An in-service record per line supports nesting: a line that outranks every line being served may interrupt again.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, every mask bit is 1, no line is in service, `irq_o` is 0 and `vec_o` is 0.
- R2: A pulse on `mask_we` loads `mask_wdata` into the mask word. Bit n = 1 makes line n's request ignored, so it raises no `irq_o`, until the bit is written to 0.
- R3: Requests are sampled at each rising clock edge. `irq_o` is 1 in the cycle after a sampled request from an eligible line. A line is eligible when it is requesting, unmasked, not in service, and outranks every in-service line.
- R4: The rank order, from highest to lowest, is lines 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7. Among several eligible lines, the highest-ranked wins.
- R5: On an `ack_i` pulse while `irq_o` is 1, `vec_o` takes the 4-bit number of the winning line and that line is marked in service. `irq_o` then falls unless another eligible line remains.
- R6: A line that ranks below, or equal to, any in-service line is not eligible. A line that outranks all in-service lines raises `irq_o` again.
- R7: An `eoi_i` pulse removes the in-service mark of the highest-ranked in-service line only.
- R8: Mask bit 2 blocks all of lines 8 to 15 at once.
- R9: A request on input 2 is never granted and never raises `irq_o`.
- R10: An `ack_i` pulse while `irq_o` is 0 leaves `vec_o` and the in-service marks unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Level request per line, bit n = line n |
| mask_we | input | 1 | Write strobe for the mask word |
| mask_wdata | input | 16 | New mask word, bit n = 1 masks line n |
| ack_i | input | 1 | One-cycle acknowledge from the processor |
| eoi_i | input | 1 | One-cycle end-of-interrupt pulse |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 4 | Number of the line granted at the last acknowledge |

## Verification
All inputs are driven on the falling clock edge, and all outputs are read on the next falling edge.

A request change or a mask write is taken at one rising edge. `irq_o` reflects it directly after that edge, so it is checked half a cycle after the stimulus edge.

An acknowledge or end-of-interrupt acts at its rising edge. The new `vec_o` and the re-evaluated `irq_o` are therefore read at the falling edge that closes the pulse.

The sweep covers every ordered pair of usable lines. The bench computes each pair's winner from a rank formula of its own.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] req_i,
  input  logic        mask_we,
  input  logic [15:0] mask_wdata,
  input  logic        ack_i,
  input  logic        eoi_i,
  output logic        irq_o,
  output logic [3:0]  vec_o
);

  logic [15:0] req_q, mask_q, isr_q;
  logic [14:0] cand;
  logic [3:0]  top_rank, win_rank;
  logic        any_cand;

  function automatic logic [3:0] line_at(input int r);
    if (r < 2)       return 4'(r);
    else if (r < 10) return 4'(r + 6);
    else             return 4'(r - 7);
  endfunction

  always_comb begin
    top_rank = 4'd15;
    for (int r = 14; r >= 0; r--)
      if (isr_q[line_at(r)]) top_rank = 4'(r);
  end

  always_comb begin
    for (int r = 0; r < 15; r++) begin
      cand[r] = req_q[line_at(r)] && !mask_q[line_at(r)] && !isr_q[line_at(r)]
                && !(line_at(r) >= 4'd8 && mask_q[2]) && (4'(r) < top_rank);
    end
  end

  always_comb begin
    win_rank = 4'd0;
    for (int r = 14; r >= 0; r--)
      if (cand[r]) win_rank = 4'(r);
  end

  assign any_cand = |cand;
  assign irq_o    = any_cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      mask_q <= '1;
      isr_q  <= '0;
      vec_o  <= '0;
    end else begin
      req_q <= req_i;
      if (mask_we) mask_q <= mask_wdata;
      if (ack_i && any_cand) vec_o <= line_at(int'(win_rank));
      isr_q <= (isr_q & ~((eoi_i && top_rank != 4'd15) ? (16'd1 << line_at(int'(top_rank))) : 16'd0))
             | ((ack_i && any_cand) ? (16'd1 << line_at(int'(win_rank))) : 16'd0);
    end
  end

endmodule

module cascade_irq_ctrl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ack_i,
  input logic        eoi_i,
  input logic        irq_o,
  input logic [3:0]  vec_o,
  input logic [15:0] isr,
  input logic [15:0] mask
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (isr == 16'd0 && mask == 16'hffff && !irq_o));

  assert_all_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 16'hffff) |-> !irq_o);

  assert_ack_grants_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> (isr[vec_o] && vec_o != 4'd2));

  assert_eoi_drops_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !ack_i && isr != 16'd0) |=> ($countones(isr) == $countones($past(isr)) - 1));

  assert_never_line2_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !isr[2]);

  assert_idle_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !eoi_i) |=> ($stable(vec_o) && $stable(isr)));

endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_checker chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .eoi_i(eoi_i),
  .irq_o(irq_o), .vec_o(vec_o), .isr(isr_q), .mask(mask_q)
);

// File: tb/cascade_irq_ctrl_test.sv
module cascade_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_i = '0;
  logic        mask_we = 1'b0;
  logic [15:0] mask_wdata = '0;
  logic        ack_i = 1'b0;
  logic        eoi_i = 1'b0;
  logic        irq_o;
  logic [3:0]  vec_o;

  int checks = 0;
  int fails = 0;

  cascade_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .ack_i(ack_i), .eoi_i(eoi_i),
    .irq_o(irq_o), .vec_o(vec_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int rank_of(input int ln);
    if (ln < 2) return ln;
    if (ln >= 8) return ln - 6;
    return ln + 7;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_mask(input logic [15:0] m);
    mask_we = 1'b1; mask_wdata = m;
    step();
    mask_we = 1'b0;
  endtask

  task automatic pulse_ack();
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
  endtask

  task automatic pulse_eoi();
    eoi_i = 1'b1;
    step();
    eoi_i = 1'b0;
  endtask

  task automatic clear_all();
    req_i = '0;
    for (int k = 0; k < 15; k++) pulse_eoi();
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
    check(vec_o == 4'd0, "R1 vec after reset", vec_o, 0);
    req_i = 16'hffff;
    step(); step();
    check(irq_o == 1'b0, "R1 all lines masked after reset", irq_o, 0);
    req_i = '0;

    write_mask(16'h0000);
    req_i = 16'h0004;
    step(); step();
    check(irq_o == 1'b0, "R9 input 2 raises nothing", irq_o, 0);
    pulse_ack();
    check(vec_o == 4'd0, "R10 ack with no request keeps vec", vec_o, 0);
    req_i = '0;
    step();

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        if (a == 2 || b == 2) continue;
        begin
          int win;
          win = (rank_of(a) <= rank_of(b)) ? a : b;
          req_i = (16'd1 << a) | (16'd1 << b);
          step();
          check(irq_o == 1'b1, "R3 irq after request", irq_o, 1);
          pulse_ack();
          check(int'(vec_o) == win, "R4 winner of pair", vec_o, win);
          check(irq_o == 1'b0, "R5 irq falls after grant", irq_o, 0);
          clear_all();
        end
      end
    end

    req_i = 16'h0080;
    step();
    pulse_ack();
    check(vec_o == 4'd7, "R5 grant line 7", vec_o, 7);
    req_i = 16'h0088;
    step();
    check(irq_o == 1'b1, "R6 line 3 preempts line 7", irq_o, 1);
    req_i = 16'h0180;
    step();
    check(irq_o == 1'b1, "R6 line 8 preempts line 7", irq_o, 1);
    pulse_ack();
    check(vec_o == 4'd8, "R6 nested grant line 8", vec_o, 8);
    req_i = 16'h1080;
    step();
    check(irq_o == 1'b0, "R6 line 12 below in-service 8", irq_o, 0);
    pulse_eoi();
    check(irq_o == 1'b1, "R7 eoi frees line 8 so 12 rises", irq_o, 1);
    pulse_ack();
    check(vec_o == 4'd12, "R7 grant line 12 after eoi", vec_o, 12);
    pulse_eoi();
    req_i = 16'h0040;
    step();
    check(irq_o == 1'b1, "R7 line 7 still in service, 6 outranks", irq_o, 1);
    req_i = 16'h0080;
    step();
    check(irq_o == 1'b0, "R7 line 7 mark kept by single eoi", irq_o, 0);
    pulse_ack();
    check(vec_o == 4'd12, "R10 idle ack keeps vec", vec_o, 12);
    clear_all();

    write_mask(16'h0004);
    for (int ln = 8; ln < 16; ln++) begin
      req_i = 16'd1 << ln;
      step();
      check(irq_o == 1'b0, "R8 mask bit 2 blocks upper line", irq_o, 0);
    end
    req_i = 16'h0008;
    step();
    check(irq_o == 1'b1, "R8 lower line 3 unaffected", irq_o, 1);
    req_i = '0;

    write_mask(16'h0020);
    req_i = 16'h0020;
    step();
    check(irq_o == 1'b0, "R2 masked line 5 ignored", irq_o, 0);
    write_mask(16'h0000);
    check(irq_o == 1'b1, "R2 line 5 after unmask", irq_o, 1);
    pulse_ack();
    check(vec_o == 4'd5, "R2 grant line 5", vec_o, 5);
    clear_all();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule